// File: doc/BRIEF.md
# Clock Gate Cell with Ownership Select and Turn-Off Hysteresis

This block produces a clock-enable for one downstream clock domain. A single 32-bit control register decides who owns the gate. When software owns it, the gate follows an enable bit in that register. When hardware owns it, the gate follows an external request line. A read-only status bit reports the real gate state after a short synchronisation lag, so software can poll it to learn when a change has taken effect.

Turning the gate off can be delayed by a selectable hysteresis window, which avoids rapid toggling when a request drops briefly. Turning it on is never delayed. If a request comes back during the window, the pending turn-off is cancelled. An elaboration option makes the gate non-disablable: under software ownership it then stays on whatever the enable bit holds.

Top module: `clkgate_hyst`

## Requirements
- R1: After reset the register reads 0, hardware owns the gate, and `clkEnOut` is 0.
- R2: Register fields: bit 0 is the enable, bit 1 the owner select (1 = software), bit 2 the hysteresis enable, bit 3 the hysteresis length (1 = long), and bit 4 the read-only status. All other bits read 0. Under software ownership `clkEnOut` takes the enable bit's value one clock edge after the write edge.
- R3: Turning on is never delayed. With hysteresis enabled, an on request still raises `clkEnOut` at the next clock edge.
- R4: Under hardware ownership `clkEnOut` follows `hwReq`, sampled at the clock edge. The enable bit has no effect.
- R5: With `KEEP_ON` = 1 and software ownership, `clkEnOut` is 1 even when the enable bit is 0.
- R6: Status bit 4 equals `clkEnOut` delayed by `SYNC_STAGES` clock edges. Writes to bit 4 are ignored.
- R7: When the on request drops and hysteresis is disabled, `clkEnOut` falls at the next edge. With hysteresis enabled it stays high for `SHORT_HYST` (bit 3 = 0) or `LONG_HYST` (bit 3 = 1) more edges.
- R8: If an on request returns during a pending hysteresis countdown, the turn-off is cancelled. A later drop restarts the full delay.
- R9: Under software ownership, `hwReq` has no effect on `clkEnOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the control register |
| regWrData | input | REG_W | Write data |
| hwReq | input | 1 | Hardware on request, used under hardware ownership |
| regRdData | output | REG_W | Register readback, including the status bit |
| clkEnOut | output | 1 | Gated clock enable |

## Verification
The gate is driven from both owners. A hardware request pulse shows that the enable bit is ignored in that mode, and a software-owned gate with a live `hwReq` shows that the request line is ignored in the other. Turn-off is tried without hysteresis, with the short window and with the long window, and the output is sampled on the last high edge and the first low edge, so an off-by-one count shows up. A turn-off that is cancelled mid-countdown and then repeated shows whether the counter restarts or continues. A second instance built non-disablable receives the same stimulus, which separates the enable-bit path from the keep-on override.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int EN_BIT    = 0;
  localparam int SEL_BIT   = 1;
  localparam int HEN_BIT   = 2;
  localparam int HLONG_BIT = 3;
  localparam int STAT_BIT  = 4;

  typedef struct packed {
    logic hystLong;
    logic hystEn;
    logic swSel;
    logic swEn;
  } ctrlBits_t;

  typedef struct packed {
    logic setOn;
    logic setOff;
  } gateStrobe_t;
endpackage

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int SHORT_HYST = 16,
  parameter int LONG_HYST  = 64,
  parameter bit KEEP_ON    = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  wrBits,
  input  logic        hwReq,
  input  logic        gateOn,
  output ctrlBits_t   ctrl,
  output gateStrobe_t strobe
);
  localparam int CW = $clog2(LONG_HYST + 1);

  logic          reqOn;
  logic          draining;
  logic [CW-1:0] holdCnt;
  logic [CW-1:0] holdDelay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl <= '0;
    end else if (regWrEn) begin
      ctrl.swEn     <= wrBits[EN_BIT];
      ctrl.swSel    <= wrBits[SEL_BIT];
      ctrl.hystEn   <= wrBits[HEN_BIT];
      ctrl.hystLong <= wrBits[HLONG_BIT];
    end
  end

  always_comb begin
    reqOn         = ctrl.swSel ? (ctrl.swEn | KEEP_ON) : hwReq;
    holdDelay     = ctrl.hystLong ? CW'(LONG_HYST) : CW'(SHORT_HYST);
    draining      = gateOn & ~reqOn;
    strobe.setOn  = reqOn & ~gateOn;
    strobe.setOff = draining & (~ctrl.hystEn | (holdCnt >= holdDelay));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!draining || strobe.setOff) begin
      holdCnt <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkgate_path.sv
module clkgate_path
  import clkgate_pkg::*;
#(
  parameter int SYNC_STAGES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  output logic        gateOn,
  output logic        statusQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOn <= 1'b0;
    end else if (strobe.setOn) begin
      gateOn <= 1'b1;
    end else if (strobe.setOff) begin
      gateOn <= 1'b0;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) statusQ <= 1'b0;
        else       statusQ <= gateOn;
      end
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], gateOn};
      end
      assign statusQ = syncQ[SYNC_STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/clkgate_hyst.sv
module clkgate_hyst
  import clkgate_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 4,
  parameter int SHORT_HYST  = 16,
  parameter int LONG_HYST   = 64,
  parameter bit KEEP_ON     = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             hwReq,
  output logic [REG_W-1:0] regRdData,
  output logic             clkEnOut
);
  ctrlBits_t   ctrl;
  gateStrobe_t strobe;
  logic        gateOn;
  logic        statusQ;
  logic        unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:STAT_BIT];

  clkgate_ctrl #(
    .SHORT_HYST(SHORT_HYST),
    .LONG_HYST (LONG_HYST),
    .KEEP_ON   (KEEP_ON)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regWrEn(regWrEn),
    .wrBits (regWrData[3:0]),
    .hwReq  (hwReq),
    .gateOn (gateOn),
    .ctrl   (ctrl),
    .strobe (strobe)
  );

  clkgate_path #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .gateOn (gateOn),
    .statusQ(statusQ)
  );

  always_comb begin
    regRdData            = '0;
    regRdData[EN_BIT]    = ctrl.swEn;
    regRdData[SEL_BIT]   = ctrl.swSel;
    regRdData[HEN_BIT]   = ctrl.hystEn;
    regRdData[HLONG_BIT] = ctrl.hystLong;
    regRdData[STAT_BIT]  = statusQ;
  end

  assign clkEnOut = gateOn;
endmodule

// File: rtl/clkgate_hyst_chk.sv
module clkgate_hyst_chk
  import clkgate_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 4,
  parameter bit KEEP_ON     = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             hwReq,
  input logic [REG_W-1:0] regRdData,
  input logic             clkEnOut
);
  logic [SYNC_STAGES:0] shadowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowQ <= '0;
    else       shadowQ <= {shadowQ[SYNC_STAGES-1:0], clkEnOut};
  end

  p_sw_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[SEL_BIT] & regRdData[EN_BIT]) |=> clkEnOut);

  p_hw_on_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[SEL_BIT] & hwReq) |=> clkEnOut);

  p_keep_on_r5: assert property (@(posedge clk) disable iff (!rstN)
    (KEEP_ON & regRdData[SEL_BIT]) |=> clkEnOut);

  p_status_lag_r6: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[STAT_BIT] == shadowQ[SYNC_STAGES-1]);

  p_sw_fast_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!KEEP_ON & regRdData[SEL_BIT] & !regRdData[EN_BIT] & !regRdData[HEN_BIT])
      |=> !clkEnOut);

  p_hw_fast_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[SEL_BIT] & !hwReq & !regRdData[HEN_BIT]) |=> !clkEnOut);
endmodule

bind clkgate_hyst clkgate_hyst_chk #(
  .REG_W      (REG_W),
  .SYNC_STAGES(SYNC_STAGES),
  .KEEP_ON    (KEEP_ON)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hwReq    (hwReq),
  .regRdData(regRdData),
  .clkEnOut (clkEnOut)
);

// File: tb/clkgate_hyst_bench.sv
`timescale 1ns/1ps
module clkgate_hyst_bench;
  localparam int S     = 4;
  localparam int SHORT = 16;
  localparam int LONG  = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        hwReq = 1'b0;
  logic [31:0] rdMain, rdKeep;
  logic        outMain, outKeep;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  typedef struct {
    int    at;
    int    sig;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkgate_hyst #(.SYNC_STAGES(S), .SHORT_HYST(SHORT), .LONG_HYST(LONG), .KEEP_ON(1'b0))
    u_clkgate_hyst (.clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
                    .hwReq(hwReq), .regRdData(rdMain), .clkEnOut(outMain));

  clkgate_hyst #(.SYNC_STAGES(S), .SHORT_HYST(SHORT), .LONG_HYST(LONG), .KEEP_ON(1'b1))
    u_clkgate_hyst_keep (.clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
                         .hwReq(hwReq), .regRdData(rdKeep), .clkEnOut(outKeep));

  function automatic logic pick(int sig);
    case (sig)
      0:       return outMain;
      1:       return rdMain[4];
      default: return outKeep;
    endcase
  endfunction

  task automatic expectAt(int delta, int sig, logic val, string tag);
    exp_t e;
    e.at = cyc + delta; e.sig = sig; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued expectations in their cycle
  initial forever begin
    @(negedge clk); #1;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        logic act;
        act = pick(sb[i].sig);
        checks++;
        if (act !== sb[i].val) begin
          errors++;
          $display("FAIL %s sig%0d cycle %0d actual %b expected %b",
                   sb[i].tag, sb[i].sig, cyc, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    check("R1 readback", rdMain, 32'h0);
    check("R1 gate off", {31'b0, outMain}, 32'h0);
    check("R1 keep-on gate off", {31'b0, outKeep}, 32'h0);

    // R4 hardware request
    hwReq = 1'b1;
    expectAt(0, 0, 1'b0, "R4 before edge");
    expectAt(1, 0, 1'b1, "R4 follows hwReq");
    expectAt(1, 2, 1'b1, "R4 keep-on follows hwReq");
    expectAt(S, 1, 1'b0, "R6 status lag");
    expectAt(S + 1, 1, 1'b1, "R6 status set");
    idle(8);
    hwReq = 1'b0;
    expectAt(1, 0, 1'b0, "R7 hw no-hyst off");
    expectAt(1, 2, 1'b0, "R4 keep-on hw off");
    expectAt(S, 1, 1'b1, "R6 status still set");
    expectAt(S + 1, 1, 1'b0, "R6 status cleared");
    idle(8);

    // R4 enable bit ignored in hardware mode
    wr(32'h1);
    expectAt(1, 0, 1'b0, "R4 enable bit ignored");
    expectAt(3, 0, 1'b0, "R4 enable bit ignored later");
    check("R2 readback hw en", rdMain, 32'h1);
    idle(6);

    // R2 software on
    wr(32'h3);
    expectAt(0, 0, 1'b0, "R2 before edge");
    expectAt(1, 0, 1'b1, "R2 sw on");
    expectAt(S + 1, 1, 1'b1, "R6 status after sw on");
    idle(8);
    check("R2 readback with status", rdMain, 32'h13);

    // R9 hwReq ignored, R5 keep-on
    hwReq = 1'b1;
    wr(32'h2);
    expectAt(1, 0, 1'b0, "R7 sw no-hyst off");
    expectAt(1, 2, 1'b1, "R5 keep-on stays on");
    expectAt(5, 0, 1'b0, "R9 hwReq ignored");
    expectAt(5, 2, 1'b1, "R5 keep-on still on");
    idle(8);
    hwReq = 1'b0;

    // R6 status bit write ignored
    wr(32'h12);
    check("R6 status write ignored", rdMain, 32'h02);
    idle(4);

    // R7 short hysteresis, R3 immediate on
    wr(32'h3);
    idle(8);
    wr(32'h6);
    expectAt(SHORT, 0, 1'b1, "R7 short hold last");
    expectAt(SHORT + 1, 0, 1'b0, "R7 short off");
    expectAt(SHORT + 1 + S, 1, 1'b0, "R6 status after hyst off");
    idle(SHORT + S + 4);
    wr(32'h7);
    expectAt(1, 0, 1'b1, "R3 on not delayed");
    idle(8);

    // R7 long hysteresis
    wr(32'hE);
    expectAt(LONG, 0, 1'b1, "R7 long hold last");
    expectAt(LONG + 1, 0, 1'b0, "R7 long off");
    idle(LONG + 6);

    // R8 cancel and restart
    wr(32'h7);
    expectAt(1, 0, 1'b1, "R8 on");
    idle(8);
    wr(32'h6);
    idle(5);
    wr(32'h7);
    expectAt(10, 0, 1'b1, "R8 cancelled");
    expectAt(30, 0, 1'b1, "R8 still on");
    idle(32);
    wr(32'h6);
    expectAt(SHORT, 0, 1'b1, "R8 full delay restarted");
    expectAt(SHORT + 1, 0, 1'b0, "R8 off after restart");
    idle(SHORT + 6);

    // R7 hysteresis under hardware ownership
    wr(32'h4);
    hwReq = 1'b1;
    expectAt(1, 0, 1'b1, "R3 hw on not delayed");
    idle(4);
    hwReq = 1'b0;
    expectAt(SHORT, 0, 1'b1, "R7 hw hold last");
    expectAt(SHORT + 1, 0, 1'b0, "R7 hw off");
    idle(SHORT + 10);

    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule